// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block turns a stream of stereo PCM sample pairs into one biphase-mark-coded serial line for a consumer digital audio link. Each audio sampling period becomes one frame. A frame holds a left subframe and then a right subframe, and each subframe has 32 time slots. A clock enable, `cell_tick`, paces the line at the half-cell rate. That rate is 128 times the sampling rate (48 kHz or 24 kHz), because every slot takes two half-cells.

A subframe opens with a 4-slot sync pattern that breaks the biphase rules on purpose. Next come a field of zero slots, then the sample sent least significant bit first, and last four flag slots: validity, user, channel status and parity. Sync patterns and flag slots keep fixed positions. The zero field is whatever room the sample width leaves; with the default 16-bit samples it is 8 slots.

A frame counter counts 192-frame blocks and is exported so the surrounding logic can present the channel-status bit for the current frame. A sample pair is taken with a valid/take handshake at the first half-cell of each frame. When no pair is offered, the frame carries silence marked invalid.

Top module: `bmc_audio_tx`

## Requirements
- R1: `line_out` is a register that changes only on a clock edge where `cell_tick` is high. One frame spans exactly 128 ticks: 64 slots, each made of 2 half-cells.
- R2: In every slot from 4 to 31, the first half-cell is the inverse of the level just before it, so the line toggles at every data slot boundary.
- R3: Slots 0–3 of a subframe carry an 8-half-cell pattern, sent MSB first and XORed with the line level before it. The pattern is 11101000 for the left subframe of frame 0, 11100010 for every other left subframe, and 11100100 for every right subframe.
- R4: Slots 4 to 11 carry logic 0. The second half-cell equals the first.
- R5: Slots 12–27 carry the latched sample, LSB in slot 12. The left subframe carries the left sample and the right subframe carries the right sample. A data bit of 1 toggles the line at mid-slot.
- R6: Slots 28, 29 and 30 carry that channel's validity, user and channel-status bits. All three are latched at the first tick of the frame.
- R7: Slot 31 is set so that slots 4–31 hold an even number of ones. As a result, the level before every sync pattern equals the level before the previous one.
- R8: `frame_num` starts at 0 and advances on the last tick of each frame. It wraps from 191 back to 0.
- R9: On the first tick of a frame (half-cell 0), if `pcm_valid` is high, both samples and both validity bits are latched. `pcm_take` is then high for exactly the next clock cycle.
- R10: If `pcm_valid` is low on that tick, both subframes of the frame carry zero samples with validity set to 1. User and channel-status bits are still taken from the inputs.
- R11: During reset, `line_out` is 0, `frame_num` is 0 and `pcm_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_tick | input | 1 | Half-cell clock enable (128 × sampling rate) |
| pcm_left | input | 16 | Left sample |
| pcm_right | input | 16 | Right sample |
| pcm_valid | input | 1 | Sample pair offered |
| pcm_take | output | 1 | One-cycle pulse: sample pair taken |
| val_left | input | 1 | Validity bit, left subframe |
| val_right | input | 1 | Validity bit, right subframe |
| usr_left | input | 1 | User bit, left subframe |
| usr_right | input | 1 | User bit, right subframe |
| cs_left | input | 1 | Channel-status bit, left subframe |
| cs_right | input | 1 | Channel-status bit, right subframe |
| frame_num | output | 8 | Frame index within the 192-frame block |
| line_out | output | 1 | Biphase-mark coded line |

## Verification
Three events can fall on the same tick: the frame counter wrapping from 191 to 0, the choice of the block-start sync pattern, and the latch of a new sample pair, possibly with no pair on offer. The bench withholds `pcm_valid` exactly at frame 0 of the second block. That one tick must then produce the block-start pattern, a silent frame with validity forced to 1, no take pulse, and a counter of 0. A behavioural model builds each frame's 128 half-cells from the requirements and compares `line_out`, `frame_num` and `pcm_take` on every clock. It does this while the tick spacing varies between 1, 2 and 3 clocks.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int SUB_SLOTS = 32;
  localparam int SYNC_SLOTS = 4;
  localparam int FLAG_SLOTS = 4;
  localparam logic [7:0] SYNC_BLOCK = 8'b1110_1000;
  localparam logic [7:0] SYNC_LEFT  = 8'b1110_0010;
  localparam logic [7:0] SYNC_RIGHT = 8'b1110_0100;

  typedef struct packed {
    logic v;
    logic u;
    logic c;
  } sub_flags_t;
endpackage

// File: rtl/tx_timebase.sv
module tx_timebase #(
  parameter int FRAMES = 192,
  parameter int POS_W  = 7,
  localparam int FR_W  = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [POS_W-1:0] hpos,
  output logic [FR_W-1:0]  frame,
  output logic             frame_start
);
  logic pos_last;
  assign pos_last    = (hpos == '1);
  assign frame_start = tick && (hpos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos  <= '0;
      frame <= '0;
    end else if (tick) begin
      hpos <= hpos + 1'b1;
      if (pos_last)
        frame <= (frame == FR_W'(FRAMES-1)) ? '0 : frame + 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    tick && pos_last && frame == FR_W'(FRAMES-1) |=> frame == '0); // R8
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(tick && pos_last) |=> $stable(frame)); // R8
endmodule

// File: rtl/tx_slot_source.sv
module tx_slot_source
  import bmc_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FR_W     = 8,
  localparam int PCM_FIRST = SUB_SLOTS - FLAG_SLOTS - SAMPLE_W,
  localparam int IDX_W     = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic [FR_W-1:0]     frame,
  input  logic [5:0]          slot_pos,
  input  logic                pcm_valid,
  input  logic [SAMPLE_W-1:0] pcm_l,
  input  logic [SAMPLE_W-1:0] pcm_r,
  input  sub_flags_t          flags_l,
  input  sub_flags_t          flags_r,
  output logic                take,
  output logic                slot_bit,
  output logic [7:0]          sync_pat
);
  logic [SAMPLE_W-1:0] held_l, held_r, pcm_sel;
  sub_flags_t          fl_l, fl_r, fl_sel;
  logic [4:0]          slot;
  logic [IDX_W-1:0]    idx;
  logic                right_half;

  assign right_half = slot_pos[5];
  assign slot       = slot_pos[4:0];
  assign pcm_sel    = right_half ? held_r : held_l;
  assign fl_sel     = right_half ? fl_r : fl_l;
  assign idx        = IDX_W'(slot - 5'(PCM_FIRST));

  always_ff @(posedge clk) begin
    if (rst) begin
      held_l <= '0;
      held_r <= '0;
      fl_l   <= '0;
      fl_r   <= '0;
      take   <= 1'b0;
    end else begin
      take <= frame_start && pcm_valid;
      if (frame_start) begin
        held_l <= pcm_valid ? pcm_l : '0;
        held_r <= pcm_valid ? pcm_r : '0;
        fl_l   <= '{v: pcm_valid ? flags_l.v : 1'b1, u: flags_l.u, c: flags_l.c};
        fl_r   <= '{v: pcm_valid ? flags_r.v : 1'b1, u: flags_r.u, c: flags_r.c};
      end
    end
  end

  always_comb begin
    if (slot < 5'(PCM_FIRST))                  slot_bit = 1'b0;
    else if (slot < 5'(SUB_SLOTS - FLAG_SLOTS)) slot_bit = pcm_sel[idx];
    else begin
      case (slot[1:0])
        2'd0:    slot_bit = fl_sel.v;
        2'd1:    slot_bit = fl_sel.u;
        2'd2:    slot_bit = fl_sel.c;
        default: slot_bit = ^{pcm_sel, fl_sel};
      endcase
    end
  end

  assign sync_pat = right_half ? SYNC_RIGHT : ((frame == '0) ? SYNC_BLOCK : SYNC_LEFT);

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take |=> !take); // R9
  AST_SILENT_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_start && !pcm_valid |=> fl_l.v && fl_r.v && held_l == '0 && held_r == '0); // R10
endmodule

// File: rtl/tx_bmc_line.sv
module tx_bmc_line (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [5:0] sub_pos,
  input  logic       slot_bit,
  input  logic [7:0] sync_pat,
  output logic       line
);
  logic       pol_q, in_sync, pol_use, lvl_nxt;
  logic [2:0] k;

  assign in_sync = (sub_pos[5:3] == 3'd0);
  assign k       = sub_pos[2:0];
  assign pol_use = (k == 3'd0) ? line : pol_q;

  always_comb begin
    if (in_sync)          lvl_nxt = sync_pat[3'd7 - k] ^ pol_use;
    else if (!sub_pos[0]) lvl_nxt = ~line;
    else                  lvl_nxt = line ^ slot_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line  <= 1'b0;
      pol_q <= 1'b0;
    end else if (tick) begin
      line <= lvl_nxt;
      if (in_sync && k == 3'd0) pol_q <= line;
    end
  end

  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line)); // R1
  AST_SLOT_EDGE: assert property (@(posedge clk) disable iff (rst)
    tick && !in_sync && !sub_pos[0] |=> line != $past(line)); // R2
  AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (rst)
    tick && in_sync && k == 3'd0 |-> line == pol_q); // R7
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FRAMES   = 192,
  localparam int FR_W    = $clog2(FRAMES),
  localparam int POS_W   = $clog2(2 * 2 * SUB_SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_tick,
  input  logic [SAMPLE_W-1:0] pcm_left,
  input  logic [SAMPLE_W-1:0] pcm_right,
  input  logic                pcm_valid,
  output logic                pcm_take,
  input  logic                val_left,
  input  logic                val_right,
  input  logic                usr_left,
  input  logic                usr_right,
  input  logic                cs_left,
  input  logic                cs_right,
  output logic [FR_W-1:0]     frame_num,
  output logic                line_out
);
  logic [POS_W-1:0] hpos;
  logic             frame_start, slot_bit;
  logic [7:0]       sync_pat;
  sub_flags_t       flags_l, flags_r;

  assign flags_l = '{v: val_left,  u: usr_left,  c: cs_left};
  assign flags_r = '{v: val_right, u: usr_right, c: cs_right};

  tx_timebase #(.FRAMES(FRAMES), .POS_W(POS_W)) u_time (
    .clk(clk), .rst(rst), .tick(cell_tick),
    .hpos(hpos), .frame(frame_num), .frame_start(frame_start)
  );

  tx_slot_source #(.SAMPLE_W(SAMPLE_W), .FR_W(FR_W)) u_src (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame(frame_num),
    .slot_pos(hpos[POS_W-1:1]), .pcm_valid(pcm_valid),
    .pcm_l(pcm_left), .pcm_r(pcm_right), .flags_l(flags_l), .flags_r(flags_r),
    .take(pcm_take), .slot_bit(slot_bit), .sync_pat(sync_pat)
  );

  tx_bmc_line u_line (
    .clk(clk), .rst(rst), .tick(cell_tick), .sub_pos(hpos[5:0]),
    .slot_bit(slot_bit), .sync_pat(sync_pat), .line(line_out)
  );
endmodule

// File: tb/bmc_audio_tx_test.sv
module bmc_audio_tx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_tick = 1'b0;
  logic [15:0] pcm_left = 16'h0, pcm_right = 16'h0;
  logic        pcm_valid = 1'b0;
  logic        val_left = 0, val_right = 0, usr_left = 0, usr_right = 0;
  logic        cs_left = 0, cs_right = 0;
  logic        pcm_take, line_out;
  logic [7:0]  frame_num;

  bmc_audio_tx uut (
    .clk(clk), .rst(rst), .cell_tick(cell_tick),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid),
    .pcm_take(pcm_take), .val_left(val_left), .val_right(val_right),
    .usr_left(usr_left), .usr_right(usr_right), .cs_left(cs_left),
    .cs_right(cs_right), .frame_num(frame_num), .line_out(line_out)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, tick_cnt = 0;
  bit second_block = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  // reference model state
  bit    exp_q[$];
  string tag_q[$];
  bit    exp_line = 0, exp_take = 0, lvl = 0;
  int    exp_frame = 0;
  string cur_tag = "R1";

  task automatic put(bit b, string t);
    exp_q.push_back(b); tag_q.push_back(t);
  endtask

  task automatic build_sub(logic [7:0] pat, logic [15:0] pcm, bit v, bit u, bit c, bit silent);
    bit start = lvl;
    bit par;
    for (int k = 0; k < 8; k++) begin
      lvl = pat[7-k] ^ start;
      put(lvl, "R3");
    end
    par = ^{pcm, v, u, c};
    for (int s = 4; s < 32; s++) begin
      bit b;
      string t;
      if (s < 12)       begin b = 0;         t = "R4"; end
      else if (s < 28)  begin b = pcm[s-12]; t = silent ? "R10" : "R5"; end
      else if (s == 28) begin b = v;         t = silent ? "R10" : "R6"; end
      else if (s == 29) begin b = u;         t = "R6"; end
      else if (s == 30) begin b = c;         t = "R6"; end
      else              begin b = par;       t = "R7"; end
      lvl = ~lvl; put(lvl, "R2");
      lvl = lvl ^ b; put(lvl, t);
    end
  endtask

  task automatic build_frame();
    bit ok = pcm_valid;
    build_sub(exp_frame == 0 ? 8'b11101000 : 8'b11100010,
              ok ? pcm_left : 16'h0, ok ? val_left : 1'b1, usr_left, cs_left, !ok);
    build_sub(8'b11100100,
              ok ? pcm_right : 16'h0, ok ? val_right : 1'b1, usr_right, cs_right, !ok);
    exp_take = ok;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_q.delete(); tag_q.delete();
      exp_line = 0; exp_take = 0; lvl = 0; exp_frame = 0; cur_tag = "R11";
    end else begin
      exp_take = 0;
      cur_tag = "R1";
      if (cell_tick) begin
        if (exp_q.size() == 0) build_frame();
        exp_line = exp_q.pop_front();
        cur_tag  = tag_q.pop_front();
        if (exp_q.size() == 0) exp_frame = (exp_frame + 1) % 192;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (cyc >= 1) begin
      if (rst) begin
        chk(line_out == 0, "R11", "reset line", line_out, 0);
        chk(frame_num == 0, "R11", "reset frame", frame_num, 0);
        chk(pcm_take == 0, "R11", "reset take", pcm_take, 0);
      end else begin
        chk(line_out == exp_line, cur_tag, "line", line_out, exp_line);
        chk(frame_num == exp_frame, "R8", "frame_num", frame_num, exp_frame);
        chk(pcm_take == exp_take, "R9", "take", pcm_take, exp_take);
      end
    end
  end

  // stimulus: ticks, samples, flags
  always @(negedge clk) begin
    int div;
    if (!rst) begin
      if (frame_num == 191) second_block = 1;
      div = (frame_num < 3) ? 1 : ((frame_num % 7 == 3) ? 3 : 2);
      tick_cnt++;
      cell_tick <= (tick_cnt % div) == 0;
      if (pcm_take) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pcm_left  <= lfsr[15:0];
        pcm_right <= lfsr[31:16] ^ 16'h5a3c;
      end
      pcm_valid <= !(frame_num == 5 || frame_num == 6 || frame_num == 100 ||
                     (frame_num == 0 && second_block));
      val_left  <= frame_num[2];
      val_right <= (frame_num == 9);
      usr_left  <= frame_num[1] ^ frame_num[4];
      usr_right <= frame_num[5];
      cs_left   <= frame_num[0];
      cs_right  <= frame_num[3] ^ frame_num[0];
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    pcm_left = 16'h8001; pcm_right = 16'h7ffe; pcm_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    wait (second_block && frame_num == 12);
    repeat (20) @(posedge clk);
    report();
  end

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    report();
  end
endmodule